// File: doc/BRIEF.md
# Paced ADC Sample Record Capture

This block runs a 16-bit successive-approximation converter at a fixed rate. It captures a fixed-length record of signed samples into on-chip memory. A start command begins a record. From then on the block pulses the converter's start line once per sample period. After each pulse it opens a receive window. In that window it drives a lane clock and shifts in two bits per system clock from two serial lanes, one bit on each lane clock edge. It then subtracts a programmable signed offset from the rebuilt sample, clamps the result to the 16-bit signed range, and writes it to the next buffer address.

When the last address has been written, conversions stop and a done flag rises. A host then reads the record through a simple address/data port. For a self-check of the receive path, a test mode compares every raw received word against the converter's fixed pattern code 0xCC3F. Any mismatch sets a sticky error flag.

Top module: `adc_record_capture`

## Requirements
- R1: While a record is in progress, `conv_start` is a one-cycle pulse every 12 clocks. The first pulse comes in the cycle after `start` is sampled high. No pulse occurs while the block is idle or done.
- R2: Number the cycles of a sample period 0 to 11, with the `conv_start` cycle as 0. Cycles 2 to 9 form the receive window. In window cycle k (0 to 7), `lane_a` carries sample bit 15-2k and `lane_b` carries bit 14-2k, so the sample arrives MSB first. `dclk` is high in cycles 2, 4, 6 and 8 and low otherwise.
- R3: Each stored value is the received two's-complement sample minus the signed `offset`. Both positive and negative offsets are handled.
- R4: A difference above +32767 is stored as 0x7FFF, and one below -32768 is stored as 0x8000. The result never wraps.
- R5: Samples are written to addresses 0 to 1023 in arrival order. A `start` command resets the write address to 0.
- R6: `done` is low while a record is captured. It rises in the cycle after the 1024th write and holds until the next `start`.
- R7: With `test_mode` high, a received raw sample other than 0xCC3F sets `pat_err`. The flag stays set until the next `start`. With `test_mode` low, samples never affect `pat_err`.
- R8: `rd_data` shows the buffer word at the `rd_addr` sampled on the previous clock edge.
- R9: During reset, `conv_start`, `done` and `pat_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 24 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new record |
| test_mode | input | 1 | Compare raw samples against the pattern code |
| offset | input | 16 | Signed offset subtracted from each sample |
| conv_start | output | 1 | Conversion start pulse to the converter |
| dclk | output | 1 | Lane clock; each edge marks a new bit pair |
| lane_a | input | 1 | Serial lane carrying the even-numbered-from-top bits (15, 13, ...) |
| lane_b | input | 1 | Serial lane carrying bits 14, 12, ... |
| done | output | 1 | Record complete |
| pat_err | output | 1 | Sticky pattern mismatch flag |
| rd_addr | input | 10 | Host read address |
| rd_data | output | 16 | Host read data, one-cycle latency |

## Verification
The bound checker watches the shapes that hold on every cycle:
- `conv_start` lasts a single cycle and never overlaps `dclk`.
- No conversion starts while `done` is high.
- `done` and `pat_err` stay set until `start`, and `start` clears both.

Other behaviour needs the bench's reference model running stimulus through whole records:
- the exact pulse spacing;
- the lane bit order;
- the offset arithmetic and its clamping with offsets of each sign;
- address order and the reset of the address on restart;
- read latency.

// File: rtl/adc_record_capture.sv
`timescale 1ns/1ps
module adc_record_capture #(
  parameter int SW          = 16,
  parameter int REC_LEN     = 1024,
  parameter int CONV_CYCLES = 12,
  parameter int RX_FIRST    = 2,
  parameter logic [SW-1:0] TEST_CODE = 16'hCC3F,
  localparam int AW = $clog2(REC_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          test_mode,
  input  logic [SW-1:0] offset,
  output logic          conv_start,
  output logic          dclk,
  input  logic          lane_a,
  input  logic          lane_b,
  output logic          done,
  output logic          pat_err,
  input  logic [AW-1:0] rd_addr,
  output logic [SW-1:0] rd_data
);
  localparam int PW       = $clog2(CONV_CYCLES);
  localparam int RX_BEATS = SW / 2;
  localparam logic [PW-1:0] P_RX0  = PW'(RX_FIRST);
  localparam logic [PW-1:0] P_RX1  = PW'(RX_FIRST + RX_BEATS - 1);
  localparam logic [PW-1:0] P_WR   = PW'(RX_FIRST + RX_BEATS);
  localparam logic [PW-1:0] P_LAST = PW'(CONV_CYCLES - 1);
  localparam logic [AW-1:0] A_LAST = AW'(REC_LEN - 1);
  localparam logic          DCLK_PAR = (RX_FIRST % 2) != 0;
  localparam logic [SW-1:0] POS_MAX = {1'b0, {(SW-1){1'b1}}};
  localparam logic [SW-1:0] NEG_MIN = {1'b1, {(SW-1){1'b0}}};

  logic          busy;
  logic [PW-1:0] ph;
  logic [AW-1:0] wr_addr;
  logic [SW-1:0] shreg;
  logic [SW-1:0] mem [REC_LEN];
  logic [SW:0]   diff;
  logic [SW-1:0] corr;
  logic          rx_win, wr_now;

  assign rx_win     = busy && (ph >= P_RX0) && (ph <= P_RX1);
  assign wr_now     = busy && (ph == P_WR);
  assign conv_start = busy && (ph == '0);
  assign dclk       = rx_win && (ph[0] == DCLK_PAR);

  assign diff = {shreg[SW-1], shreg} - {offset[SW-1], offset};
  assign corr = (diff[SW] != diff[SW-1]) ? (diff[SW] ? NEG_MIN : POS_MAX) : diff[SW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      ph      <= '0;
      wr_addr <= '0;
      shreg   <= '0;
      done    <= 1'b0;
      pat_err <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      ph      <= '0;
      wr_addr <= '0;
      done    <= 1'b0;
      pat_err <= 1'b0;
    end else if (busy) begin
      ph <= (ph == P_LAST) ? '0 : ph + 1'b1;
      if (rx_win)
        shreg <= {shreg[SW-3:0], lane_a, lane_b};
      if (wr_now) begin
        wr_addr <= wr_addr + 1'b1;
        if (test_mode && shreg != TEST_CODE)
          pat_err <= 1'b1;
        if (wr_addr == A_LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_now)
      mem[wr_addr] <= corr;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/adc_record_capture_checks.sv
`timescale 1ns/1ps
module adc_record_capture_checks (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic conv_start,
  input logic dclk,
  input logic done,
  input logic pat_err
);
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  a_r2_no_dclk_on_conv: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !dclk);
  a_r6_idle_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !conv_start);
  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_err && !start) |=> pat_err);
  a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !pat_err));
  always_comb
    if (!rst_n) a_r9_reset_quiet: assert (!conv_start && !done && !pat_err);
endmodule

bind adc_record_capture adc_record_capture_checks u_checks (
  .clk(clk), .rst_n(rst_n), .start(start), .conv_start(conv_start),
  .dclk(dclk), .done(done), .pat_err(pat_err)
);

// File: tb/test_adc_record_capture.sv
`timescale 1ns/1ps
module test_adc_record_capture;
  logic clk = 0, rst_n = 0, start = 0, test_mode = 0, lane_a = 0, lane_b = 0;
  logic [15:0] offset = '0;
  logic [9:0]  rd_addr = '0;
  logic conv_start, dclk, done, pat_err;
  logic [15:0] rd_data;

  adc_record_capture i_adc_record_capture (
    .clk(clk), .rst_n(rst_n), .start(start), .test_mode(test_mode), .offset(offset),
    .conv_start(conv_start), .dclk(dclk), .lane_a(lane_a), .lane_b(lane_b),
    .done(done), .pat_err(pat_err), .rd_addr(rd_addr), .rd_data(rd_data));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit m_busy = 0, m_done = 0, m_perr = 0;
  int m_ph = 0, m_addr = 0;
  logic [15:0] m_mem [1024];
  logic [15:0] cur = '0;
  int sq[$];
  bit st_req = 0, rd_go = 0, rd_en = 0;
  int rd_a = 0, rd_prev = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sat_sub(input logic [15:0] s, input logic [15:0] o);
    int v;
    v = int'($signed(s)) - int'($signed(o));
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return 16'(v);
  endfunction

  task automatic tick();
    bit e_conv, e_dclk;
    int k;
    @(negedge clk);
    e_conv = m_busy && m_ph == 0;
    e_dclk = m_busy && m_ph >= 2 && m_ph <= 9 && (m_ph % 2 == 0);
    chk(conv_start === e_conv, "R1 conv_start", 32'(conv_start), 32'(e_conv));
    chk(dclk === e_dclk, "R2 dclk", 32'(dclk), 32'(e_dclk));
    chk(done === m_done, "R6 done", 32'(done), 32'(m_done));
    chk(pat_err === m_perr, "R7 pat_err", 32'(pat_err), 32'(m_perr));
    if (rd_en)
      chk(rd_data === m_mem[rd_prev], "R8/R3/R4/R5 rd_data", 32'(rd_data), 32'(m_mem[rd_prev]));
    rd_en = rd_go; rd_prev = rd_a; rd_addr = 10'(rd_a);
    start = st_req;
    if (m_busy && m_ph == 0) cur = (sq.size() > 0) ? 16'(sq.pop_front()) : 16'h0;
    if (m_busy && m_ph >= 2 && m_ph <= 9) begin
      k = m_ph - 2;
      lane_a = cur[15-2*k];
      lane_b = cur[14-2*k];
    end else begin
      lane_a = 0; lane_b = 0;
    end
    if (!rst_n) return;
    if (st_req) begin
      m_busy = 1; m_ph = 0; m_addr = 0; m_done = 0; m_perr = 0;
    end else if (m_busy) begin
      if (m_ph == 10) begin
        m_mem[m_addr] = sat_sub(cur, offset);
        if (test_mode && cur != 16'hCC3F) m_perr = 1;
        m_addr++;
        if (m_addr == 1024) begin m_busy = 0; m_done = 1; end
      end
      m_ph = (m_ph == 11) ? 0 : m_ph + 1;
    end
  endtask

  task automatic run_record();
    st_req = 1; tick(); st_req = 0;
    for (int i = 0; i < 1024*12 + 8; i++) tick();
    chk(done === 1'b1, "R6 done after record", 32'(done), 32'h1);
  endtask

  task automatic read_back(input int n);
    rd_go = 1;
    for (int a = 0; a < n; a++) begin rd_a = a; tick(); end
    rd_go = 0; tick(); tick();
  endtask

  initial begin
    #1600000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) tick();
    chk(!conv_start && !done && !pat_err, "R9 reset state", {29'h0, conv_start, done, pat_err}, 32'h0);
    rst_n = 1;
    for (int i = 0; i < 20; i++) tick();
    chk(conv_start === 1'b0, "R1 idle no pulse", 32'(conv_start), 32'h0);

    // Record A: positive offset, test mode off (R3, R4 low clamp, R7 no effect)
    offset = 16'd189; test_mode = 0;
    sq.delete();
    for (int i = 0; i < 1024; i++)
      case (i)
        0: sq.push_back(-32768);
        1: sq.push_back(32767);
        2: sq.push_back(0);
        3: sq.push_back(-32600);
        default: sq.push_back(((i * 7919) % 65536) - 32768);
      endcase
    run_record();
    chk(pat_err === 1'b0, "R7 test mode off ignored", 32'(pat_err), 32'h0);
    read_back(1024);

    // Record B: negative offset, high clamp, restart clears address (R4, R5)
    offset = 16'(-300);
    sq.delete();
    for (int i = 0; i < 1024; i++)
      case (i)
        0: sq.push_back(32767);
        1: sq.push_back(32500);
        2: sq.push_back(-32768);
        default: sq.push_back(((i * 4099 + 123) % 65536) - 32768);
      endcase
    run_record();
    read_back(1024);
    chk(m_mem[0] === 16'h7FFF && m_mem[2] === 16'h812C, "R4 expected clamp values", 32'(m_mem[0]), 32'h7FFF);

    // Record C: test mode, clean pattern (R7)
    offset = 16'h0; test_mode = 1;
    sq.delete();
    for (int i = 0; i < 1024; i++) sq.push_back(int'($signed(16'hCC3F)));
    run_record();
    chk(pat_err === 1'b0, "R7 clean pattern", 32'(pat_err), 32'h0);
    read_back(16);

    // Record D: one corrupted word sets the flag
    sq.delete();
    for (int i = 0; i < 1024; i++) sq.push_back(i == 500 ? int'($signed(16'hCC3E)) : int'($signed(16'hCC3F)));
    run_record();
    chk(pat_err === 1'b1, "R7 mismatch flagged", 32'(pat_err), 32'h1);

    st_req = 1; tick(); st_req = 0; tick();
    chk(pat_err === 1'b0 && done === 1'b0, "R6/R7 start clears flags", {30'h0, pat_err, done}, 32'h0);
    for (int i = 0; i < 40; i++) tick();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule